// File: doc/BRIEF.md
# Truncated Compensated Powering Unit

This block raises a short unsigned fraction to a small integer power (square, cube or fourth power) and returns only the most significant bits of the result. It is meant to sit beside a coefficient table in a piecewise-polynomial function evaluator. That evaluator needs the power of the low input slice only to a limited precision, so carrying the full-width product would waste area.

The input fraction is widened by one constant-one bit below its least significant bit. This half-ulp centres the error that comes from truncating the input. Inside each multiplication stage, partial products below a fixed weight threshold are never generated. A constant equal to half their largest possible total, rounded to the threshold grid, is added in their place. The sum keeps the bits at or above the threshold, saturates instead of wrapping, and is cut down to the output width. A third power is a truncated square followed by a truncated multiply by the input. A fourth power is a truncated square of the truncated square. An optional output register is provided.

Top module: `pow_trunc_unit`

## Requirements
- R1: The operand is v = (2·B + 1) / 2^(IN_W+1), where B is the unsigned input; for B all ones, K = 3 and the default widths, the output is within one of 1018.
- R2: With K = 3, for every input the output differs by at most one from floor(v^3 · 2^LAMBDA); each truncated stage stays within half its dropped-term total plus one grid step of the exact product.
- R3: With K = 2, for every input the output differs by at most one from floor(v^2 · 2^LAMBDA).
- R4: With K = 4, for every input the output differs by at most one from floor(v^4 · 2^LAMBDA).
- R5: An input of zero gives an output of zero for every K.
- R6: The output's top bit (bit LAMBDA-1) is set only when the input's top bit (bit IN_W-1) is set.
- R7: While rst_n is low and REG_OUT = 1, the output is zero.
- R8: With REG_OUT = 1, a new input appears at the output after the next rising clock edge and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| b_in | input | IN_W | Unsigned input fraction, MSB weight one half |
| p_out | output | LAMBDA | Most significant bits of the K-th power, MSB weight one half |

## Verification
The error-bound assertions compare each truncated stage with its exact product. They assume only that the stage operands are fully known, so they are gated off while the input carries unknown bits. That is the case before the bench first drives b_in, and the bench drives it from time zero. The zero-input and top-bit assertions rely on the default widths, which leave a tolerance wide enough for the compensation constant to stay below one output ulp. The bench therefore instantiates only configurations inside that margin. It sweeps every input value in order and then a seeded random sequence, for each power. The reference is an exact integer power of 2·B + 1.

// File: rtl/pow_trunc_pkg.sv
package pow_trunc_pkg;

   // Largest total of the partial products a squarer drops below column t.
   // Cross terms are merged (weight doubled); diagonal terms are single bits.
   function automatic longint sqr_drop_sum(int w, int t);
      longint s = 0;
      for (int i = 0; i < w; i++) begin
         for (int j = i; j < w; j++) begin
            if (i == j) begin
               if (2 * i < t) s = s + (64'sd1 <<< (2 * i));
            end else if (i + j < t) begin
               s = s + (64'sd1 <<< (i + j + 1));
            end
         end
      end
      return s;
   endfunction

   // Largest total of the partial products a general multiplier drops.
   function automatic longint mul_drop_sum(int aw, int bw, int t);
      longint s = 0;
      for (int i = 0; i < aw; i++)
         for (int j = 0; j < bw; j++)
            if (i + j < t) s = s + (64'sd1 <<< (i + j));
      return s;
   endfunction

   // Half the dropped total, rounded to the nearest step of 2^t, in steps.
   function automatic longint comp_steps(longint s, int t);
      if (t <= 0) return 0;
      return (s + (64'sd1 <<< t)) >>> (t + 1);
   endfunction

   function automatic longint abs_gap(longint x, longint y);
      return (x > y) ? (x - y) : (y - x);
   endfunction

endpackage

// File: rtl/pt_squarer.sv
module pt_squarer
   import pow_trunc_pkg::*;
#(
   parameter int W  = 9,
   parameter int MU = 14
) (
   input  logic [W-1:0]  a,
   output logic [MU-1:0] r
);
   localparam int     T     = 2 * W - MU;
   localparam int     ACC_W = 2 * W + 1;
   localparam longint S     = sqr_drop_sum(W, T);
   localparam longint C     = comp_steps(S, T);

   initial begin
      assert (MU <= 2 * W && MU >= 1) else $error("pt_squarer: MU out of range");
      assert (2 * W <= 60) else $error("pt_squarer: W too wide");
   end

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] res_full;

   always_comb begin
      acc = '0;
      for (int i = 0; i < W; i++) begin
         for (int j = i; j < W; j++) begin
            if (i == j) begin
               if (2 * i >= T) acc = acc + (ACC_W'(a[i]) << (2 * i));
            end else if (i + j >= T) begin
               acc = acc + (ACC_W'(a[i] & a[j]) << (i + j + 1));
            end
         end
      end
   end

   assign res_full = (acc >> T) + ACC_W'(C);

   always_comb begin
      if ((res_full >> MU) != '0) r = '1;
      else                        r = res_full[MU-1:0];
   end

   always_comb begin
      if (!$isunknown(a)) begin
         // R2
         sq_err_chk: assert (2 * abs_gap(longint'(a) * longint'(a), longint'(r) <<< T)
                             <= S + (64'sd2 <<< T))
            else $error("squarer error bound exceeded");
      end
   end
endmodule

// File: rtl/pt_trunc_mul.sv
module pt_trunc_mul
   import pow_trunc_pkg::*;
#(
   parameter int AW = 14,
   parameter int BW = 9,
   parameter int MU = 14
) (
   input  logic [AW-1:0] a,
   input  logic [BW-1:0] b,
   output logic [MU-1:0] r
);
   localparam int     T     = AW + BW - MU;
   localparam int     ACC_W = AW + BW + 1;
   localparam longint S     = mul_drop_sum(AW, BW, T);
   localparam longint C     = comp_steps(S, T);

   initial begin
      assert (MU <= AW + BW && MU >= 1) else $error("pt_trunc_mul: MU out of range");
      assert (AW + BW <= 60) else $error("pt_trunc_mul: operands too wide");
   end

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] res_full;

   always_comb begin
      acc = '0;
      for (int i = 0; i < AW; i++)
         for (int j = 0; j < BW; j++)
            if (i + j >= T) acc = acc + (ACC_W'(a[i] & b[j]) << (i + j));
   end

   assign res_full = (acc >> T) + ACC_W'(C);

   always_comb begin
      if ((res_full >> MU) != '0) r = '1;
      else                        r = res_full[MU-1:0];
   end

   always_comb begin
      if (!$isunknown(a) && !$isunknown(b)) begin
         // R2
         mul_err_chk: assert (2 * abs_gap(longint'(a) * longint'(b), longint'(r) <<< T)
                              <= S + (64'sd2 <<< T))
            else $error("multiplier error bound exceeded");
      end
   end
endmodule

// File: rtl/pow_trunc_unit.sv
module pow_trunc_unit #(
   parameter int IN_W    = 8,
   parameter int K       = 3,
   parameter int MU      = 14,
   parameter int LAMBDA  = 10,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IN_W-1:0]   b_in,
   output logic [LAMBDA-1:0] p_out
);
   localparam int E = IN_W + 1;   // operand width with the half-ulp bit

   initial begin
      assert (K >= 2 && K <= 4) else $error("pow_trunc_unit: K must be 2, 3 or 4");
      assert (LAMBDA <= MU && LAMBDA >= 1) else $error("pow_trunc_unit: LAMBDA > MU");
      assert (MU <= 2 * E) else $error("pow_trunc_unit: MU wider than square");
   end

   logic [E-1:0]      opnd;
   logic [MU-1:0]     sq;
   logic [MU-1:0]     fin;
   logic [LAMBDA-1:0] p_comb;

   assign opnd = {b_in, 1'b1};

   pt_squarer #(.W(E), .MU(MU)) u_sq (.a(opnd), .r(sq));

   if (K == 2) begin : g_pow2
      assign fin = sq;
   end else if (K == 3) begin : g_pow3
      pt_trunc_mul #(.AW(MU), .BW(E), .MU(MU)) u_mul (.a(sq), .b(opnd), .r(fin));
   end else begin : g_pow4
      pt_squarer #(.W(MU), .MU(MU)) u_sq2 (.a(sq), .r(fin));
   end

   assign p_comb = fin[MU-1 -: LAMBDA];

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) p_out <= '0;
         else        p_out <= p_comb;
      end
   end else begin : g_comb
      assign p_out = p_comb;
   end

   always_comb begin
      if (!$isunknown(b_in)) begin
         // R5
         zero_in_chk: assert (b_in != '0 || p_comb == '0)
            else $error("zero input gave nonzero power");
         // R6
         msb_chk: assert (!p_comb[LAMBDA-1] || b_in[IN_W-1])
            else $error("output MSB set with input below one half");
      end
   end
endmodule

// File: tb/pow_trunc_unit_tb.sv
`timescale 1ns/1ps
module pow_trunc_unit_tb;
   localparam int IN_W = 8;
   localparam int LAM  = 10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [IN_W-1:0] b_in = '0;
   logic [LAM-1:0]  p3, p2, p4;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   pow_trunc_unit #(.IN_W(IN_W), .K(3), .MU(14), .LAMBDA(LAM), .REG_OUT(1'b1))
      u_dut (.clk(clk), .rst_n(rst_n), .b_in(b_in), .p_out(p3));
   pow_trunc_unit #(.IN_W(IN_W), .K(2), .MU(14), .LAMBDA(LAM), .REG_OUT(1'b1))
      u_dut_k2 (.clk(clk), .rst_n(rst_n), .b_in(b_in), .p_out(p2));
   pow_trunc_unit #(.IN_W(IN_W), .K(4), .MU(16), .LAMBDA(LAM), .REG_OUT(1'b1))
      u_dut_k4 (.clk(clk), .rst_n(rst_n), .b_in(b_in), .p_out(p4));

   function automatic longint ref_pow(int v, int k);
      longint u = 2 * longint'(v) + 1;
      longint p = 1;
      for (int i = 0; i < k; i++) p = p * u;
      return p >>> (k * (IN_W + 1) - LAM);
   endfunction

   task automatic chk(string req, longint act, longint exp, longint tol);
      longint d = (act > exp) ? act - exp : exp - act;
      tests++;
      if (d > tol) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (tolerance %0d)", req, act, exp, tol);
      end
   endtask

   task automatic apply_and_check(int v);
      @(negedge clk);
      b_in = IN_W'(v);
      @(posedge clk);
      #1;
      chk("R2 cube", p3, ref_pow(v, 3), 1);
      chk("R3 square", p2, ref_pow(v, 2), 1);
      chk("R4 fourth", p4, ref_pow(v, 4), 1);
      if (v == 0) begin
         chk("R5 zero cube", p3, 0, 0);
         chk("R5 zero square", p2, 0, 0);
         chk("R5 zero fourth", p4, 0, 0);
      end
      if (v < (1 << (IN_W - 1))) begin
         chk("R6 msb cube", p3[LAM-1], 0, 0);
         chk("R6 msb fourth", p4[LAM-1], 0, 0);
      end
   endtask

   initial begin
      #(8 * 20000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // R7: output held at zero during reset
      b_in = '1;
      repeat (3) @(posedge clk);
      #1;
      chk("R7 reset cube", p3, 0, 0);
      chk("R7 reset square", p2, 0, 0);
      chk("R7 reset fourth", p4, 0, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: all-ones input uses the half-ulp operand
      apply_and_check((1 << IN_W) - 1);
      chk("R1 half-ulp", p3, 1018, 1);

      // R8: new input appears only after the next rising edge
      apply_and_check(0);
      @(negedge clk);
      b_in = '1;
      #2;
      chk("R8 before edge", p3, 0, 0);
      @(posedge clk);
      #1;
      chk("R8 after edge", p3, ref_pow((1 << IN_W) - 1, 3), 1);

      // R2 R3 R4: full sweep
      for (int v = 0; v < (1 << IN_W); v++) apply_and_check(v);

      // seeded random sequence
      void'($urandom(32'd2024));
      for (int n = 0; n < 400; n++) apply_and_check(int'($urandom() % (1 << IN_W)));

      // directed corners
      apply_and_check(1 << (IN_W - 1));
      apply_and_check((1 << (IN_W - 1)) - 1);
      apply_and_check(1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule